// File: doc/BRIEF.md
# Interrupt Request Qualification Logic

This block decides, every cycle, whether an interrupt should be taken and which source wins. It serves eight sources. Sources 0 to 6 are input pins, each followed by a two-stage synchroniser and a selectable edge detector. Source 7 is a periodic timer tick. Each source has a sticky trigger flag. Software clears a flag by writing a one to its bit.

A flag only leads to a request when four more conditions hold in the same cycle. The source must be armed. Its controller enable must be set, except for the timer, which bypasses the enable. The global mask bit must be clear. Its 3-bit priority must beat both the current execution level and the nonzero priority threshold. Among the qualified sources, the lowest priority value wins, and equal values go to the lowest index. The result appears as a take strobe and a source number. Stacking and vector fetch belong to the consumer of these outputs.

Top module: `irq_qualify`

## Requirements
- R1: `take_o` is high only while some source has its flag set, its arm bit set, its enable set (timer excepted), the mask bit clear, and a priority value strictly below `cur_lvl_i` (4 bits, 8 = no handler active).
- R2: The conditions may become true in any order. `take_o` rises combinationally in the cycle the last one holds; a register write shows from the clock edge that stores it.
- R3: Mask bit 1 blocks every source. Mask bit 0 allows them. The mask resets to 1.
- R4: A nonzero threshold N passes only priority values below N.
- R5: A threshold of 0 applies no threshold masking.
- R6: `take_id_o` names the qualified source with the lowest priority value. Ties go to the lowest index.
- R7: Source 7 (timer) sets its flag on the edge after `tick_i` is high. It needs no enable bit.
- R8: Pin edge select per pin: 2'b00 none, 2'b01 rising (reset value), 2'b10 falling, 2'b11 both. The flag is set on the third clock edge after the pin changes (two synchroniser stages, then detection).
- R9: Flags stay set until written 1 on `clr_wdata_i`. A clear and a new trigger in the same cycle leave the flag set.
- R10: After reset, arm, enable, priorities, threshold and flags are zero, the mask is 1, and `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 7 | Asynchronous pin sources 0..6 |
| tick_i | input | 1 | Timer tick, source 7 |
| cur_lvl_i | input | 4 | Current execution priority level |
| arm_we_i | input | 1 | Arm register write |
| arm_wdata_i | input | 8 | Arm bits |
| en_we_i | input | 1 | Enable register write |
| en_wdata_i | input | 8 | Enable bits |
| mask_we_i | input | 1 | Mask write |
| mask_wdata_i | input | 1 | Global mask bit |
| thr_we_i | input | 1 | Threshold write |
| thr_wdata_i | input | 3 | Threshold value |
| prio_we_i | input | 1 | Priority write |
| prio_idx_i | input | 3 | Source whose priority is written |
| prio_wdata_i | input | 3 | Priority value |
| edge_we_i | input | 1 | Edge select write |
| edge_idx_i | input | 3 | Pin whose edge select is written |
| edge_wdata_i | input | 2 | Edge select code |
| clr_we_i | input | 1 | Flag clear write |
| clr_wdata_i | input | 8 | Write-one-to-clear flag bits |
| flags_o | output | 8 | Trigger flags |
| take_o | output | 1 | Interrupt is taken |
| take_id_o | output | 3 | Winning source |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a software clear and a new trigger land on the same flag. The bench drives a clear of the timer flag on the same clock edge as a timer tick, and requires the flag to read back as set. In the second, two qualified sources request at once. The bench arms two pins with set flags, then moves their priorities across and onto each other, and checks both the lower-value winner and the lower-index tie-break.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int N_PIN = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_PIN-1:0]      pin_i,
  input  logic [N_PIN-1:0][1:0] edge_sel_i,
  output logic [N_PIN-1:0]      hit_o
);
  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign hit_o[g] = (edge_sel_i[g][0] & s2_q & ~prev_q) |
                      (edge_sel_i[g][1] & ~s2_q & prev_q);

    p_hit_needs_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[g] |-> (edge_sel_i[g] != irq_pkg::EDGE_NONE));
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;  // set beats clear
  end
  assign flags_o = flag_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_o[g]);
    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
  output logic                          valid_o,
  output logic [ID_W-1:0]               id_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    best    = '1;
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (req_i[i] && (!valid_o || prio_i[i] < best)) begin
        valid_o = 1'b1;
        id_o    = i[ID_W-1:0];
        best    = prio_i[i];
      end
    end
  end

  p_win_is_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[id_o]);
  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> !valid_o);
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  localparam int N_PIN = N_SRC - 1,
  localparam int TIMER_IDX = N_SRC - 1,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIN-1:0]  pin_i,
  input  logic              tick_i,
  input  logic [PRIO_W:0]   cur_lvl_i,
  input  logic              arm_we_i,
  input  logic [N_SRC-1:0]  arm_wdata_i,
  input  logic              en_we_i,
  input  logic [N_SRC-1:0]  en_wdata_i,
  input  logic              mask_we_i,
  input  logic              mask_wdata_i,
  input  logic              thr_we_i,
  input  logic [PRIO_W-1:0] thr_wdata_i,
  input  logic              prio_we_i,
  input  logic [ID_W-1:0]   prio_idx_i,
  input  logic [PRIO_W-1:0] prio_wdata_i,
  input  logic              edge_we_i,
  input  logic [ID_W-1:0]   edge_idx_i,
  input  logic [1:0]        edge_wdata_i,
  input  logic              clr_we_i,
  input  logic [N_SRC-1:0]  clr_wdata_i,
  output logic [N_SRC-1:0]  flags_o,
  output logic              take_o,
  output logic [ID_W-1:0]   take_id_o
);
  import irq_pkg::*;

  logic [N_SRC-1:0]             arm_q, en_q;
  logic                         mask_q;
  logic [PRIO_W-1:0]            thr_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_PIN-1:0][1:0]        edge_q;
  logic [N_PIN-1:0]             pin_hit;
  logic [N_SRC-1:0]             flags, qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= '0;
      en_q   <= '0;
      mask_q <= 1'b1;
      thr_q  <= '0;
      prio_q <= '0;
      for (int i = 0; i < N_PIN; i++) edge_q[i] <= EDGE_RISE;
    end else begin
      if (arm_we_i)  arm_q  <= arm_wdata_i;
      if (en_we_i)   en_q   <= en_wdata_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (thr_we_i)  thr_q  <= thr_wdata_i;
      if (prio_we_i) prio_q[prio_idx_i] <= prio_wdata_i;
      if (edge_we_i && int'(edge_idx_i) < N_PIN) edge_q[edge_idx_i] <= edge_wdata_i;
    end
  end

  irq_pin_edge #(.N_PIN(N_PIN)) u_pins (
    .clk_i, .rst_ni, .pin_i, .edge_sel_i(edge_q), .hit_o(pin_hit)
  );

  irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk_i, .rst_ni,
    .set_i  ({tick_i, pin_hit}),
    .clr_i  (clr_we_i ? clr_wdata_i : '0),
    .flags_o(flags)
  );
  assign flags_o = flags;

  for (genvar g = 0; g < N_SRC; g++) begin : g_qual
    localparam bit BYPASS_EN = (g == TIMER_IDX);
    logic en_ok, thr_ok, lvl_ok;
    assign en_ok  = BYPASS_EN ? 1'b1 : en_q[g];
    assign thr_ok = (thr_q == '0) || (prio_q[g] < thr_q);
    assign lvl_ok = {1'b0, prio_q[g]} < cur_lvl_i;
    assign qual[g] = flags[g] & arm_q[g] & en_ok & ~mask_q & thr_ok & lvl_ok;
  end

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk_i, .rst_ni, .req_i(qual), .prio_i(prio_q),
    .valid_o(take_o), .id_o(take_id_o)
  );

  p_mask_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !take_o);
  p_needs_flag_arm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (flags_o[take_id_o] && arm_q[take_id_o]));
  p_beats_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ({1'b0, prio_q[take_id_o]} < cur_lvl_i));
  p_threshold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && thr_q != '0) |-> (prio_q[take_id_o] < thr_q));
endmodule

// File: tb/sim_irq_qualify.sv
module sim_irq_qualify;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] pin = '0;
  logic       tick = 1'b0;
  logic [3:0] cur_lvl = 4'd0;
  logic       arm_we = 0, en_we = 0, mask_we = 0, thr_we = 0, prio_we = 0, edge_we = 0, clr_we = 0;
  logic [7:0] arm_wd = '0, en_wd = '0, clr_wd = '0;
  logic       mask_wd = 1'b0;
  logic [2:0] thr_wd = '0, prio_idx = '0, prio_wd = '0, edge_idx = '0;
  logic [1:0] edge_wd = '0;
  logic [7:0] flags;
  logic       take;
  logic [2:0] take_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    bit         tk;
    logic [2:0] id;
    logic [7:0] fl;
  } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_qualify u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tick_i(tick), .cur_lvl_i(cur_lvl),
    .arm_we_i(arm_we), .arm_wdata_i(arm_wd), .en_we_i(en_we), .en_wdata_i(en_wd),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .thr_we_i(thr_we), .thr_wdata_i(thr_wd),
    .prio_we_i(prio_we), .prio_idx_i(prio_idx), .prio_wdata_i(prio_wd),
    .edge_we_i(edge_we), .edge_idx_i(edge_idx), .edge_wdata_i(edge_wd),
    .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
    .flags_o(flags), .take_o(take), .take_id_o(take_id)
  );

  // monitor: compare outputs against queued expectations
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (take !== e.tk || (e.tk && take_id !== e.id) || flags !== e.fl) begin
          errors++;
          $display("FAIL %s: take=%b id=%0d flags=%h, expected take=%b id=%0d flags=%h",
                   e.tag, take, take_id, flags, e.tk, e.id, e.fl);
        end
      end
    end
  end

  task automatic expect_st(string tag, bit tk, int id, logic [7:0] fl);
    exp_t e;
    #1;
    e.tag = tag; e.tk = tk; e.id = id[2:0]; e.fl = fl;
    exp_q.push_back(e);
    ->sample_ev;
    wait (exp_q.size() == 0);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_arm(logic [7:0] v);
    @(negedge clk); arm_we = 1; arm_wd = v; @(negedge clk); arm_we = 0;
  endtask
  task automatic wr_en(logic [7:0] v);
    @(negedge clk); en_we = 1; en_wd = v; @(negedge clk); en_we = 0;
  endtask
  task automatic wr_mask(logic v);
    @(negedge clk); mask_we = 1; mask_wd = v; @(negedge clk); mask_we = 0;
  endtask
  task automatic wr_thr(logic [2:0] v);
    @(negedge clk); thr_we = 1; thr_wd = v; @(negedge clk); thr_we = 0;
  endtask
  task automatic wr_prio(logic [2:0] idx, logic [2:0] v);
    @(negedge clk); prio_we = 1; prio_idx = idx; prio_wd = v; @(negedge clk); prio_we = 0;
  endtask
  task automatic wr_edge(logic [2:0] idx, logic [1:0] v);
    @(negedge clk); edge_we = 1; edge_idx = idx; edge_wd = v; @(negedge clk); edge_we = 0;
  endtask
  task automatic wr_clr(logic [7:0] v);
    @(negedge clk); clr_we = 1; clr_wd = v; @(negedge clk); clr_we = 0;
  endtask
  task automatic set_pin(int idx, logic v);
    @(negedge clk); pin[idx] = v; cycles(4);
  endtask
  task automatic pulse_tick();
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
  endtask
  task automatic clr_with_tick(logic [7:0] v);
    @(negedge clk); tick = 1; clr_we = 1; clr_wd = v;
    @(negedge clk); tick = 0; clr_we = 0;
  endtask
  task automatic set_lvl(logic [3:0] v);
    @(negedge clk); cur_lvl = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    expect_st("R10 reset state", 0, 0, 8'h00);

    // R8: default rising select, then falling ignored
    set_pin(0, 1); expect_st("R8 rising edge sets flag", 0, 0, 8'h01);
    set_pin(0, 0); expect_st("R8 falling ignored by rise select", 0, 0, 8'h01);
    wr_clr(8'h01); expect_st("R9 write-one clears flag", 0, 0, 8'h00);

    // R2: conditions arrive one at a time
    set_pin(0, 1); expect_st("R2 flag only", 0, 0, 8'h01);
    wr_arm(8'h01); expect_st("R2 flag+arm", 0, 0, 8'h01);
    wr_en(8'h01);  expect_st("R2 flag+arm+en", 0, 0, 8'h01);
    set_lvl(4'd8); expect_st("R3 mask at reset blocks", 0, 0, 8'h01);
    wr_mask(1'b0); expect_st("R2 last condition fires take", 1, 0, 8'h01);
    wr_mask(1'b1); expect_st("R3 mask set blocks", 0, 0, 8'h01);
    wr_mask(1'b0); expect_st("R3 mask clear allows", 1, 0, 8'h01);

    // R1: each condition removed alone
    set_lvl(4'd0); expect_st("R1 level not beaten", 0, 0, 8'h01);
    set_lvl(4'd8);
    wr_en(8'h00);  expect_st("R1 enable missing", 0, 0, 8'h01);
    wr_en(8'h01);
    wr_arm(8'h00); expect_st("R1 arm missing", 0, 0, 8'h01);
    wr_arm(8'h01); expect_st("R1 all conditions", 1, 0, 8'h01);

    // R4/R5 threshold
    wr_prio(3'd0, 3'd3);
    wr_thr(3'd3);  expect_st("R4 threshold 3 blocks level 3", 0, 0, 8'h01);
    wr_thr(3'd4);  expect_st("R4 threshold 4 passes level 3", 1, 0, 8'h01);
    wr_thr(3'd0);  expect_st("R5 threshold 0 passes", 1, 0, 8'h01);
    wr_prio(3'd0, 3'd7); expect_st("R5 threshold 0 passes level 7", 1, 0, 8'h01);
    set_lvl(4'd7); expect_st("R1 level 7 not below 7", 0, 0, 8'h01);
    set_lvl(4'd8);

    // R8 falling select on pin 2, then R6 arbitration
    wr_edge(3'd2, 2'b10);
    set_pin(2, 1); expect_st("R8 rise ignored by fall select", 1, 0, 8'h01);
    set_pin(2, 0); expect_st("R8 falling edge sets flag", 1, 0, 8'h05);
    wr_arm(8'h05); wr_en(8'h05);
    wr_prio(3'd0, 3'd5); wr_prio(3'd2, 3'd2);
    expect_st("R6 lower value wins", 1, 2, 8'h05);
    wr_prio(3'd2, 3'd5); expect_st("R6 tie to lower index", 1, 0, 8'h05);
    wr_prio(3'd0, 3'd6); expect_st("R6 lower value wins again", 1, 2, 8'h05);
    wr_clr(8'h05); expect_st("R9 clear two flags", 0, 0, 8'h00);

    // R7 timer bypasses enable
    pulse_tick(); expect_st("R7 tick sets flag", 0, 0, 8'h80);
    wr_arm(8'h85); expect_st("R7 timer taken without enable", 1, 7, 8'h80);

    // R9 clear and trigger in the same cycle
    clr_with_tick(8'h80); expect_st("R9 set wins over clear", 1, 7, 8'h80);
    wr_clr(8'h80); expect_st("R9 plain clear", 0, 0, 8'h00);

    // R8 both edges on pin 1
    wr_edge(3'd1, 2'b11);
    set_pin(1, 1); expect_st("R8 both: rising sets", 0, 0, 8'h02);
    wr_clr(8'h02);
    set_pin(1, 0); expect_st("R8 both: falling sets", 0, 0, 8'h02);
    wr_clr(8'h02);

    // R8 none on pin 3
    wr_edge(3'd3, 2'b00);
    set_pin(3, 1); set_pin(3, 0);
    expect_st("R8 none select ignores edges", 0, 0, 8'h00);

    // R4 nonzero threshold against timer
    pulse_tick();
    wr_thr(3'd1); expect_st("R4 threshold 1 passes level 0", 1, 7, 8'h80);
    wr_prio(3'd7, 3'd1); expect_st("R4 threshold 1 blocks level 1", 0, 0, 8'h80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule